// File: doc/BRIEF.md
# Window and Hysteresis Trigger Detector

This block watches a stream of 8-bit sample codes and sends out a single-cycle trigger pulse when the stream meets a chosen threshold condition. The codes may come from the upper bits of an acquisition channel or from a separate trigger converter. In bipolar use, code 0x80 stands for zero and 0xFF for the step just below positive full scale. Two threshold codes, a low one and a high one, are set at the ports. A 3-bit selector picks one of five conditions:

| Select | Condition | Fires when | Re-arms when |
|---|---|---|---|
| 0 | below-low | code < low | code >= low |
| 1 | above-high | code > high | code <= high |
| 2 | inside-region | low < code < high | code is outside that range |
| 3 | high-hysteresis | code > high | code < low |
| 4 | low-hysteresis | code < low | code > high |

Values 5 to 7 are reserved. In the two hysteresis conditions the second threshold only re-arms the detector and never fires it.

The detector fires on entry into the firing region, not on every sample that stays inside it. After it fires, it waits for a re-arming sample before it can fire again. The same rule applies when the arm input rises: the first sample must re-arm the detector, so arming while the signal already sits in the firing region cannot cause a trigger at once. A high threshold at or below the low threshold is a bad setting. It is shown on an error output, and no trigger is produced while the setting stays bad.

Top module: `winTrigDetect`

## Requirements
- R1: After reset, trigPulse and the internal trigger state are cleared. No pulse is produced until the detector has been armed and has seen a re-arming sample.
- R2: With condSel = 0 (below-low), a sample with code < lowCode fires. A code equal to lowCode is not below it. highCode has no effect on the decision.
- R3: With condSel = 1 (above-high), a sample with code > highCode fires. A code equal to highCode is not above it. lowCode has no effect on the decision.
- R4: With condSel = 2 (inside-region), a sample fires when lowCode < code < highCode, with both bounds strict.
- R5: In conditions 0, 1 and 2, a pulse comes only on entry into the firing region. Further firing samples give no pulse until a non-firing sample has been seen.
- R6: With condSel = 3 (high-hysteresis), a code > highCode fires. The detector re-arms only on a code < lowCode, so samples between the thresholds do not re-arm it.
- R7: With condSel = 4 (low-hysteresis), a code < lowCode fires. The detector re-arms only on a code > highCode.
- R8: After arm rises, the first sample must be a re-arming sample before any trigger can occur. A firing sample seen first gives no pulse.
- R9: cfgError is high whenever highCode <= lowCode. While it is high, no pulse is produced and the detector returns to waiting for a re-arming sample.
- R10: A firing sample presented with sampleValid at rising edge k makes trigPulse high for exactly the one cycle after edge k+1.
- R11: While arm is low, samples are ignored and produce no pulse. Lowering arm discards any re-armed state.
- R12: With condSel = 5, 6 or 7, no pulse is ever produced.
- R13: A code presented with sampleValid low has no effect on the pulse or on the trigger state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleCode | input | 8 | Sample code to compare |
| sampleValid | input | 1 | Marks sampleCode as a new sample |
| lowCode | input | 8 | Low threshold code |
| highCode | input | 8 | High threshold code |
| condSel | input | 3 | Condition select (0 to 4; 5 to 7 reserved) |
| arm | input | 1 | Enables detection when high |
| trigPulse | output | 1 | Single-cycle trigger pulse |
| cfgError | output | 1 | High when highCode <= lowCode |

## Verification
The assertions assume that all inputs are synchronous to clk. They also assume that the thresholds and condSel do not change while a captured sample waits one cycle to be evaluated, so that a pulse always follows a capture made under the same setting. The stimulus follows these rules. It changes the input pins only on falling edges. It changes condSel only while arm is low. It changes the thresholds only between samples, after the pulse of the previous sample has been observed.

// File: rtl/winTrigPkg.sv
package winTrigPkg;

  localparam logic [2:0] COND_BELOW   = 3'd0;
  localparam logic [2:0] COND_ABOVE   = 3'd1;
  localparam logic [2:0] COND_INSIDE  = 3'd2;
  localparam logic [2:0] COND_HYST_HI = 3'd3;
  localparam logic [2:0] COND_HYST_LO = 3'd4;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capture;
    logic flush;
  } ctrlStrobe_t;

  // Registered comparison results handed back to the control
  typedef struct packed {
    logic fresh;
    logic belowLow;
    logic aboveHigh;
    logic insideWin;
  } cmpFlags_t;

  typedef enum logic {
    ST_WAIT_REARM = 1'b0,
    ST_READY      = 1'b1
  } trigState_e;

endpackage

// File: rtl/trigCmpPath.sv
module trigCmpPath
  import winTrigPkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic [CODE_W-1:0] lowCode,
  input  logic [CODE_W-1:0] highCode,
  input  ctrlStrobe_t       strobe,
  output cmpFlags_t         flags,
  output logic              cfgError
);

  logic isBelow;
  logic isAbove;

  assign isBelow  = sampleCode < lowCode;
  assign isAbove  = sampleCode > highCode;
  assign cfgError = highCode <= lowCode;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      flags <= '0;
    end else begin
      flags.fresh <= strobe.capture;
      if (strobe.capture) begin
        flags.belowLow  <= isBelow;
        flags.aboveHigh <= isAbove;
        flags.insideWin <= (sampleCode > lowCode) && (sampleCode < highCode);
      end
    end
  end

  // R11
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> !flags.fresh);

  // R13
  fresh_needs_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> !flags.fresh);

endmodule

// File: rtl/trigCtrl.sv
module trigCtrl
  import winTrigPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        arm,
  input  logic [2:0]  condSel,
  input  cmpFlags_t   flags,
  input  logic        cfgError,
  output ctrlStrobe_t strobe,
  output logic        trigPulse
);

  trigState_e state;
  logic       fire;
  logic       rearm;

  assign strobe.capture = sampleValid && arm;
  assign strobe.flush   = !arm;

  always_comb begin
    fire  = 1'b0;
    rearm = 1'b0;
    case (condSel)
      COND_BELOW:   begin fire = flags.belowLow;  rearm = !flags.belowLow;  end
      COND_ABOVE:   begin fire = flags.aboveHigh; rearm = !flags.aboveHigh; end
      COND_INSIDE:  begin fire = flags.insideWin; rearm = !flags.insideWin; end
      COND_HYST_HI: begin fire = flags.aboveHigh; rearm = flags.belowLow;   end
      COND_HYST_LO: begin fire = flags.belowLow;  rearm = flags.aboveHigh;  end
      default:      begin fire = 1'b0;            rearm = 1'b0;             end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_WAIT_REARM;
      trigPulse <= 1'b0;
    end else begin
      trigPulse <= 1'b0;
      if (!arm || cfgError) begin
        state <= ST_WAIT_REARM;
      end else if (flags.fresh) begin
        case (state)
          ST_WAIT_REARM: if (rearm) state <= ST_READY;
          ST_READY: if (fire) begin
            trigPulse <= 1'b1;
            state     <= ST_WAIT_REARM;
          end
          default: state <= ST_WAIT_REARM;
        endcase
      end
    end
  end

  // R10
  single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  // R13
  pulse_needs_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(flags.fresh));

  // R9
  no_trig_on_error_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |=> !trigPulse);

  // R11
  no_trig_disarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !arm |=> !trigPulse);

  // R12
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (condSel > COND_HYST_LO) |=> !trigPulse);

endmodule

// File: rtl/winTrigDetect.sv
module winTrigDetect
  import winTrigPkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic              sampleValid,
  input  logic [CODE_W-1:0] lowCode,
  input  logic [CODE_W-1:0] highCode,
  input  logic [2:0]        condSel,
  input  logic              arm,
  output logic              trigPulse,
  output logic              cfgError
);

  ctrlStrobe_t strobe;
  cmpFlags_t   flags;

  trigCmpPath #(.CODE_W(CODE_W)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .sampleCode (sampleCode),
    .lowCode    (lowCode),
    .highCode   (highCode),
    .strobe     (strobe),
    .flags      (flags),
    .cfgError   (cfgError)
  );

  trigCtrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .arm         (arm),
    .condSel     (condSel),
    .flags       (flags),
    .cfgError    (cfgError),
    .strobe      (strobe),
    .trigPulse   (trigPulse)
  );

endmodule

// File: tb/test_winTrigDetect.sv
module test_winTrigDetect;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sampleCode = '0;
  logic       sampleValid = 1'b0;
  logic [7:0] lowCode = 8'h60;
  logic [7:0] highCode = 8'hA0;
  logic [2:0] condSel = '0;
  logic       arm = 1'b0;
  logic       trigPulse;
  logic       cfgError;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  winTrigDetect i_winTrigDetect (
    .clk(clk), .rstN(rstN), .sampleCode(sampleCode), .sampleValid(sampleValid),
    .lowCode(lowCode), .highCode(highCode), .condSel(condSel), .arm(arm),
    .trigPulse(trigPulse), .cfgError(cfgError)
  );

  // Row: {requirement[3:0], condSel[2:0], code[7:0], expected pulse}
  // thresholds low = 0x60, high = 0xA0
  localparam int NV = 34;
  localparam logic [15:0] VEC [NV] = '{
    {4'd2,  3'd0, 8'h70, 1'b0},  // R2 re-arming sample
    {4'd2,  3'd0, 8'h50, 1'b1},  // R2 below fires
    {4'd5,  3'd0, 8'h40, 1'b0},  // R5 still below, no repeat
    {4'd2,  3'd0, 8'h60, 1'b0},  // R2 equal to low is not below
    {4'd2,  3'd0, 8'h5F, 1'b1},  // R2
    {4'd8,  3'd1, 8'hB0, 1'b0},  // R8 firing sample right after arm
    {4'd3,  3'd1, 8'h90, 1'b0},  // R3 re-arm
    {4'd3,  3'd1, 8'hC0, 1'b1},  // R3
    {4'd5,  3'd1, 8'hFF, 1'b0},  // R5
    {4'd3,  3'd1, 8'hA0, 1'b0},  // R3 equal to high is not above
    {4'd3,  3'd1, 8'hA1, 1'b1},  // R3
    {4'd4,  3'd2, 8'h20, 1'b0},  // R4 re-arm outside
    {4'd4,  3'd2, 8'h80, 1'b1},  // R4
    {4'd5,  3'd2, 8'h90, 1'b0},  // R5
    {4'd4,  3'd2, 8'h60, 1'b0},  // R4 low bound is outside
    {4'd4,  3'd2, 8'h61, 1'b1},  // R4
    {4'd4,  3'd2, 8'hA0, 1'b0},  // R4 high bound is outside
    {4'd4,  3'd2, 8'h9F, 1'b1},  // R4
    {4'd6,  3'd3, 8'h50, 1'b0},  // R6 re-arm below low
    {4'd6,  3'd3, 8'hB0, 1'b1},  // R6
    {4'd6,  3'd3, 8'h80, 1'b0},  // R6 inside band
    {4'd6,  3'd3, 8'hB5, 1'b0},  // R6 band did not re-arm
    {4'd6,  3'd3, 8'h5F, 1'b0},  // R6 re-arm
    {4'd6,  3'd3, 8'hA1, 1'b1},  // R6
    {4'd7,  3'd4, 8'hB0, 1'b0},  // R7 re-arm above high
    {4'd7,  3'd4, 8'h50, 1'b1},  // R7
    {4'd7,  3'd4, 8'h80, 1'b0},  // R7
    {4'd7,  3'd4, 8'h40, 1'b0},  // R7 band did not re-arm
    {4'd7,  3'd4, 8'hA1, 1'b0},  // R7 re-arm
    {4'd7,  3'd4, 8'h10, 1'b1},  // R7
    {4'd12, 3'd5, 8'h50, 1'b0},  // R12
    {4'd12, 3'd5, 8'hB0, 1'b0},  // R12
    {4'd12, 3'd5, 8'h10, 1'b0},  // R12
    {4'd12, 3'd7, 8'hF0, 1'b0}   // R12
  };

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the pulse cycle
  task automatic pushSample(input logic [7:0] c, output logic seen);
    sampleCode = c;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    @(negedge clk);
    seen = trigPulse;
  endtask

  task automatic rearmWith(input logic [2:0] c);
    arm = 1'b0;
    @(negedge clk);
    condSel = c;
    arm = 1'b1;
  endtask

  initial begin
    logic seen;
    logic [2:0] prevCond;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset pulse", trigPulse, 1'b0);
    check("R1 reset error flag", cfgError, 1'b0);
    pushSample(8'h10, seen);
    check("R1 unarmed", seen, 1'b0);

    prevCond = 3'd7;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][11:9] != prevCond) rearmWith(VEC[i][11:9]);
      prevCond = VEC[i][11:9];
      pushSample(VEC[i][8:1], seen);
      checks++;
      if (seen !== VEC[i][0]) begin
        errors++;
        $display("FAIL R%0d row %0d: got %0b expected %0b", VEC[i][15:12], i, seen, VEC[i][0]);
      end
    end

    // R2: the high threshold has no effect on below-low
    rearmWith(3'd0);
    highCode = 8'hFE;
    pushSample(8'hF0, seen);
    check("R2 high ignored rearm", seen, 1'b0);
    pushSample(8'h10, seen);
    check("R2 high ignored fire", seen, 1'b1);
    highCode = 8'hA0;

    // R10: pulse timing and width
    pushSample(8'h70, seen);
    sampleCode = 8'h10;
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
    check("R10 no pulse after capture edge", trigPulse, 1'b0);
    @(negedge clk);
    check("R10 pulse after next edge", trigPulse, 1'b1);
    @(negedge clk);
    check("R10 one cycle wide", trigPulse, 1'b0);

    // R13: invalid samples have no effect
    pushSample(8'h70, seen);
    sampleCode = 8'h10;
    repeat (3) @(negedge clk);
    check("R13 invalid code ignored", trigPulse, 1'b0);
    pushSample(8'h10, seen);
    check("R13 ready state kept", seen, 1'b1);

    // R11: disarmed samples ignored, and disarm clears re-armed state
    pushSample(8'h70, seen);
    arm = 1'b0;
    pushSample(8'h10, seen);
    check("R11 disarmed sample", seen, 1'b0);
    arm = 1'b1;
    pushSample(8'h10, seen);
    check("R11 re-arm state cleared", seen, 1'b0);
    pushSample(8'h70, seen);
    pushSample(8'h10, seen);
    check("R11 fires after re-arm", seen, 1'b1);

    // R9: bad threshold setting
    pushSample(8'h70, seen);
    highCode = 8'h60;
    #1;
    check("R9 error flag equal", cfgError, 1'b1);
    pushSample(8'h10, seen);
    check("R9 no pulse on error", seen, 1'b0);
    highCode = 8'h50;
    #1;
    check("R9 error flag inverted", cfgError, 1'b1);
    highCode = 8'hA0;
    #1;
    check("R9 error flag clear", cfgError, 1'b0);
    pushSample(8'h10, seen);
    check("R9 state reset by error", seen, 1'b0);
    pushSample(8'h70, seen);
    pushSample(8'h10, seen);
    check("R9 recovers", seen, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule